// File: doc/BRIEF.md
# Microstep Position Translator

This block turns a step-and-direction command stream into drive commands for a two-phase bipolar stepper motor. It keeps the rotor's electrical position as an index from 0 to 31 that covers one electrical cycle in eighth-step units. Each accepted rising edge on the step input moves the index by an amount set by the resolution select. The direction input decides whether the index counts up or down. From the index, the block looks up a current magnitude and a polarity bit for each of the two windings on a sine/cosine curve. A downstream regulator turns these into winding currents.

The block has three controls. An active-low reset clears the position to the home index and blocks all stepping. A sleep input, active low, turns the drive off and presets the position to home. When the block wakes, it refuses step edges for a programmable number of clock cycles, so the power stage can recover. An active-low enable only gates the drive commands. The stored position keeps tracking steps while the drive is disabled. A home flag marks the index at which both windings carry equal current.

Top module: `stepper_translator`

## Requirements
- R1: The step input passes through a two-flop synchronizer, and only a low-to-high transition counts. If the step input is first sampled high at clock edge n, the position changes at edge n+2. A step held high for any length of time produces exactly one move.
- R2: The index wraps modulo 32. Direction high adds the step size to the index and direction low subtracts it, so index 31 plus 1 gives 0, and 0 minus 1 gives 31.
- R3: The resolution select `res_sel` is sampled in the cycle in which the edge is taken. It sets the step size in index units: 00 gives 8 (full), 01 gives 4 (half), 10 gives 2 (quarter) and 11 gives 1 (eighth).
- R4: While `rst_n` is low, the position is 4 (home), `drive_on` is 0, both magnitudes are 0, and step edges have no effect on the position.
- R5: While `sleep_n` is low, the following hold:
  - `drive_on` and both magnitudes are 0.
  - The position is forced to 4.
  - Step edges are ignored.
- R6: After `sleep_n` returns high, step edges are ignored for WAKE_CYCLES clock cycles. Edges after that window are accepted.
- R7: When `enable_n` is high, `drive_on` is 0 and both magnitudes and polarities are 0. The position still follows accepted steps.
- R8: `home_o` is 1 exactly when the position equals 4.
- R9: While driving, the outputs follow the position p as follows:
  - `mag_b` is round(255·|sin(p·π/16)|) and `pol_b` is 1 when p < 16.
  - `mag_a` uses the same rule at index (p+8) mod 32, and so does `pol_a`.
  - Outside driving, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; presets the position to home |
| step_in | input | 1 | Step command; a rising edge moves one step |
| dir_in | input | 1 | Direction: 1 counts up, 0 counts down |
| res_sel | input | 2 | Resolution select: 00 full, 01 half, 10 quarter, 11 eighth |
| sleep_n | input | 1 | Active-low sleep; presets home, then wake lockout |
| enable_n | input | 1 | Active-low drive enable |
| pos_o | output | 5 | Electrical position index, 0 to 31 |
| home_o | output | 1 | High when the position is the home index |
| drive_on | output | 1 | High when the windings are being commanded |
| mag_a | output | 8 | Winding A current magnitude |
| pol_a | output | 1 | Winding A polarity |
| mag_b | output | 8 | Winding B current magnitude |
| pol_b | output | 1 | Winding B polarity |

## Verification
Step trains are run at each of the four resolutions in both directions.
- Trains that cross index 0 from above and from below separate correct modulo wrapping from saturating or sign errors.
- A step held high for many cycles shows whether the design responds to the edge or to the level.
- Sampling the position on each cycle just after an edge pins the synchronizer latency to exactly two edges.
- Pulses during reset, during sleep, inside the wake window and just after it show which gate decides acceptance.
- Toggling enable between steps shows that the position keeps counting while the magnitudes are held at zero.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

  localparam int POS_W    = 5;
  localparam int IDX_N    = 1 << POS_W;
  localparam int HOME_IDX = 4;
  localparam int MAG_W    = 8;
  localparam int QTR_N    = IDX_N / 4;

  typedef logic [POS_W-1:0] pos_t;
  typedef logic [MAG_W-1:0] mag_t;

  typedef enum logic [1:0] {
    RES_FULL    = 2'b00,
    RES_HALF    = 2'b01,
    RES_QUARTER = 2'b10,
    RES_EIGHTH  = 2'b11
  } res_e;

  // Index units moved per accepted edge.
  function automatic pos_t step_delta(res_e r);
    case (r)
      RES_FULL:    step_delta = pos_t'(QTR_N);
      RES_HALF:    step_delta = pos_t'(QTR_N / 2);
      RES_QUARTER: step_delta = pos_t'(QTR_N / 4);
      default:     step_delta = pos_t'(1);
    endcase
  endfunction

  // Next position with modulo wrap.
  function automatic pos_t advance(pos_t p, logic up, res_e r);
    advance = up ? pos_t'(p + step_delta(r)) : pos_t'(p - step_delta(r));
  endfunction

  // 255*sin(k*pi/16) for k = 0..8, rounded.
  function automatic mag_t quarter_mag(logic [3:0] k);
    case (k)
      4'd0:    quarter_mag = 8'd0;
      4'd1:    quarter_mag = 8'd50;
      4'd2:    quarter_mag = 8'd98;
      4'd3:    quarter_mag = 8'd142;
      4'd4:    quarter_mag = 8'd180;
      4'd5:    quarter_mag = 8'd212;
      4'd6:    quarter_mag = 8'd236;
      4'd7:    quarter_mag = 8'd250;
      default: quarter_mag = 8'd255;
    endcase
  endfunction

  // |sin| over the full cycle: fold each half onto the first quadrant.
  function automatic mag_t sine_mag(pos_t p);
    logic [3:0] m;
    logic [3:0] k;
    m = p[3:0];
    k = (m > 4'd8) ? 4'(5'd16 - {1'b0, m}) : m;
    sine_mag = quarter_mag(k);
  endfunction

  // Positive half of the cycle.
  function automatic logic sine_pol(pos_t p);
    sine_pol = ~p[POS_W-1];
  endfunction

endpackage

// File: rtl/step_edge_sync.sv
module step_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_in,
  output logic step_rise
);

  // chain[0..SYNC_STAGES-1] synchronize, the last flop remembers the previous level
  logic [SYNC_STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_STAGES-1:0], step_in};
  end

  assign step_rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

endmodule

// File: rtl/wake_lockout.sv
module wake_lockout #(
  parameter int WAKE_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n,
  output logic wake_busy
);

  localparam int CNT_W = $clog2(WAKE_CYCLES + 1);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain_q <= '0;
    else if (!sleep_n)        remain_q <= CNT_W'(WAKE_CYCLES);
    else if (remain_q != '0)  remain_q <= remain_q - 1'b1;
  end

  assign wake_busy = (remain_q != '0);

endmodule

// File: rtl/phase_accum.sv
module phase_accum
  import stepper_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_n,
  input  logic       step_take,
  input  logic       dir_in,
  input  logic [1:0] res_sel,
  output pos_t       pos_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pos_q <= pos_t'(HOME_IDX);
    else if (!sleep_n)  pos_q <= pos_t'(HOME_IDX);
    else if (step_take) pos_q <= advance(pos_q, dir_in, res_e'(res_sel));
  end

endmodule

// File: rtl/winding_drive.sv
module winding_drive
  import stepper_pkg::*;
#(
  parameter int OFFSET = 0
) (
  input  pos_t pos,
  input  logic drive_on,
  output mag_t mag_o,
  output logic pol_o
);

  pos_t phase;

  assign phase = pos_t'(pos + pos_t'(OFFSET));
  assign mag_o = drive_on ? sine_mag(phase) : '0;
  assign pol_o = drive_on & sine_pol(phase);

endmodule

// File: rtl/stepper_translator.sv
module stepper_translator
  import stepper_pkg::*;
#(
  parameter int WAKE_CYCLES = 50000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_in,
  input  logic       dir_in,
  input  logic [1:0] res_sel,
  input  logic       sleep_n,
  input  logic       enable_n,
  output logic [4:0] pos_o,
  output logic       home_o,
  output logic       drive_on,
  output logic [7:0] mag_a,
  output logic       pol_a,
  output logic [7:0] mag_b,
  output logic       pol_b
);

  localparam int WINDINGS = 2;

  // Named internal events, visible to the checker
  logic step_rise;
  logic wake_busy;
  logic step_take;
  pos_t pos_q;

  step_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_in  (step_in),
    .step_rise(step_rise)
  );

  wake_lockout #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_n  (sleep_n),
    .wake_busy(wake_busy)
  );

  assign step_take = step_rise & sleep_n & ~wake_busy;

  phase_accum u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_n  (sleep_n),
    .step_take(step_take),
    .dir_in   (dir_in),
    .res_sel  (res_sel),
    .pos_q    (pos_q)
  );

  assign drive_on = rst_n & sleep_n & ~enable_n;
  assign pos_o    = pos_q;
  assign home_o   = (pos_q == pos_t'(HOME_IDX));

  // Winding 0 (A) leads by a quarter cycle (cosine), winding 1 (B) is sine.
  mag_t mag_w [WINDINGS];
  logic pol_w [WINDINGS];

  for (genvar w = 0; w < WINDINGS; w++) begin : g_wind
    winding_drive #(.OFFSET(w == 0 ? QTR_N : 0)) u_wd (
      .pos     (pos_q),
      .drive_on(drive_on),
      .mag_o   (mag_w[w]),
      .pol_o   (pol_w[w])
    );
  end

  assign mag_a = mag_w[0];
  assign pol_a = pol_w[0];
  assign mag_b = mag_w[1];
  assign pol_b = pol_w[1];

endmodule

// File: rtl/stepper_translator_chk.sv
module stepper_translator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_n,
  input logic       dir_in,
  input logic [1:0] res_sel,
  input logic       step_take,
  input logic       wake_busy,
  input logic       drive_on,
  input logic       home_o,
  input logic [4:0] pos_o,
  input logic [7:0] mag_a,
  input logic [7:0] mag_b
);

  // R1
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_n && !step_take) |=> $stable(pos_o));

  // R3
  full_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_take && dir_in && res_sel == 2'b00) |=> pos_o == 5'($past(pos_o) + 5'd8));

  // R5
  sleep_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> (pos_o == 5'd4));

  // R6
  wake_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_n) |-> wake_busy);

  // R6
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_busy |-> !step_take);

  // R7
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_on |-> (mag_a == 8'd0 && mag_b == 8'd0));

  // R8
  home_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (home_o && drive_on) |-> (mag_a == mag_b));

endmodule

bind stepper_translator stepper_translator_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sleep_n  (sleep_n),
  .dir_in   (dir_in),
  .res_sel  (res_sel),
  .step_take(step_take),
  .wake_busy(wake_busy),
  .drive_on (drive_on),
  .home_o   (home_o),
  .pos_o    (pos_o),
  .mag_a    (mag_a),
  .mag_b    (mag_b)
);

// File: tb/stepper_translator_bench.sv
module stepper_translator_bench;

  localparam int WAKE = 40;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, step_in, dir_in, sleep_n, enable_n;
  logic [1:0] res_sel;
  logic [4:0] pos_o;
  logic       home_o, drive_on, pol_a, pol_b;
  logic [7:0] mag_a, mag_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  stepper_translator #(.WAKE_CYCLES(WAKE)) u_stepper_translator (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_in(dir_in),
    .res_sel(res_sel), .sleep_n(sleep_n), .enable_n(enable_n),
    .pos_o(pos_o), .home_o(home_o), .drive_on(drive_on),
    .mag_a(mag_a), .pol_a(pol_a), .mag_b(mag_b), .pol_b(pol_b)
  );

  // Behavioural reference model
  int m_pos = 4;
  int m_lock = 0;
  int hist[$] = '{0, 0, 0};   // step levels seen at the last three edges, newest first

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 4; m_lock = 0; hist = '{0, 0, 0};
    end else begin
      bit rise;
      rise = (hist[1] == 1) && (hist[2] == 0);
      if (!sleep_n) begin
        m_pos = 4; m_lock = WAKE;
      end else begin
        if (rise && m_lock == 0)
          m_pos = (m_pos + (dir_in ? 1 : -1) * (8 >> res_sel) + 32) % 32;
        if (m_lock > 0) m_lock--;
      end
      hist = '{int'(step_in), hist[0], hist[1]};
    end
  end

  function automatic int ref_mag(int p);
    real s;
    s = $sin(p * 3.14159265358979 / 16.0);
    if (s < 0.0) s = -s;
    return $rtoi(255.0 * s + 0.5);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit drv;
    int pa;
    drv = rst_n && sleep_n && !enable_n;
    pa = (m_pos + 8) % 32;
    chk("R1 pos", int'(pos_o), m_pos);
    chk("R8 home", int'(home_o), int'(m_pos == 4));
    chk("R7 drive_on", int'(drive_on), int'(drv));
    chk("R9 mag_a", int'(mag_a), drv ? ref_mag(pa) : 0);
    chk("R9 mag_b", int'(mag_b), drv ? ref_mag(m_pos) : 0);
    chk("R9 pol_a", int'(pol_a), int'(drv && pa < 16));
    chk("R9 pol_b", int'(pol_b), int'(drv && m_pos < 16));
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic pulse();
    step_in = 1'b1; tick(4);
    step_in = 1'b0; tick(4);
  endtask

  initial begin
    rst_n = 0; step_in = 0; dir_in = 1; res_sel = 2'b00; sleep_n = 1; enable_n = 0;
    tick(3);
    chk("R4 reset pos", int'(pos_o), 4);
    chk("R4 reset drive", int'(drive_on), 0);
    chk("R4 reset mag", int'(mag_a), 0);
    pulse();
    chk("R4 step in reset ignored", int'(pos_o), 4);
    rst_n = 1; tick(4);
    chk("R4 drive after release", int'(drive_on), 1);
    chk("R9 home mag_a", int'(mag_a), 180);
    chk("R9 home mag_b", int'(mag_b), 180);
    chk("R8 home flag", int'(home_o), 1);

    pulse();
    chk("R3 full fwd", int'(pos_o), 12);
    chk("R9 pol_a negative", int'(pol_a), 0);
    repeat (3) pulse();
    chk("R2 wrap up", int'(pos_o), 4);

    dir_in = 0; res_sel = 2'b01; pulse();
    chk("R3 half rev", int'(pos_o), 0);
    chk("R8 home off", int'(home_o), 0);
    chk("R9 peak mag_a", int'(mag_a), 255);
    chk("R9 zero mag_b", int'(mag_b), 0);
    res_sel = 2'b11; pulse();
    chk("R2 wrap down", int'(pos_o), 31);
    res_sel = 2'b10; pulse();
    chk("R3 quarter rev", int'(pos_o), 29);

    // R1 latency and level insensitivity
    dir_in = 1; res_sel = 2'b11;
    step_in = 1; tick(2);
    chk("R1 not yet moved", int'(pos_o), 29);
    tick(1);
    chk("R1 moved on third edge", int'(pos_o), 30);
    tick(20);
    chk("R1 held high one step", int'(pos_o), 30);
    step_in = 0; tick(4);

    // R7 enable gates drive only
    enable_n = 1; tick(1);
    chk("R7 disabled mag", int'(mag_b), 0);
    pulse();
    chk("R7 pos tracks while disabled", int'(pos_o), 31);
    enable_n = 0; tick(1);
    chk("R7 re-enabled mag_b", int'(mag_b), 50);

    // R5 sleep
    sleep_n = 0; tick(2);
    chk("R5 sleep home", int'(pos_o), 4);
    chk("R5 sleep drive off", int'(drive_on), 0);
    pulse();
    chk("R5 step in sleep ignored", int'(pos_o), 4);

    // R6 wake lockout
    sleep_n = 1; pulse();
    chk("R6 step in lockout ignored", int'(pos_o), 4);
    tick(WAKE);
    pulse();
    chk("R6 step after lockout", int'(pos_o), 5);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule